// File: doc/BRIEF.md
# Four-Bit Synchronous Up/Down Counter with Cascade Carry

This block is a small binary counter that changes state only on the rising clock edge. On each edge it takes one of four actions: it clears, it loads a parallel word, it steps one count up or down, or it keeps its value. Loading is requested with an active-low strobe. Counting is requested with two active-low enables, and both must be asserted for the count to move. A direction input chooses whether the count increments or decrements, and the count wraps modulo 2^WIDTH.

The block also has an active-low carry output for building wider counters. The carry is decoded combinationally from three things: the current count, the direction and the second enable. It goes low when that enable is asserted and the count is at the last value for the current direction. That value is all ones when counting up and zero when counting down. To chain stages, connect each stage's carry to the next stage's second enable and share the first enable, load and clock across all stages. The chained stages then behave as one wider synchronous up/down counter.

Top module: `updown_counter4`

## Requirements
- R1: When `rst` is high at a rising edge, the count becomes 0. This takes priority over load and counting.
- R2: When `rst` is low and `load_n` is low at a rising edge, `q` takes the value of `din`. Load takes priority over both enables and the direction input.
- R3: When `rst` is high-free (low), `load_n` is high, and both `en_p_n` and `en_t_n` are low, the count changes on each rising edge. It goes up by one when `up` is 1 and down by one when `up` is 0, wrapping modulo 16 in both directions (15→0 and 0→15).
- R4: When `load_n` is high and either `en_p_n` or `en_t_n` is high, `q` keeps its value across the rising edge.
- R5: `carry_n` is low exactly when `en_t_n` is low and `q` is at the terminal value for the current direction: 15 when `up` is 1, 0 when `up` is 0. It responds to changes on `up` and `en_t_n` without waiting for a clock edge.
- R6: `en_p_n` has no effect on `carry_n`.
- R7: Two stages chained through `carry_n` into the next stage's `en_t_n`, with `en_p_n` shared, count as one 8-bit up/down counter. This includes the 255→0 and 0→255 wraps and the borrow or carry across the nibble boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high clear |
| load_n | input | 1 | Active-low synchronous parallel load |
| en_p_n | input | 1 | Active-low count enable; does not affect carry |
| en_t_n | input | 1 | Active-low count enable; also gates carry |
| up | input | 1 | Direction: 1 counts up, 0 counts down |
| din | input | WIDTH | Parallel load data |
| q | output | WIDTH | Current count |
| carry_n | output | 1 | Active-low terminal-count carry |

## Verification
The following rules are checked by assertions on every clock cycle:
- the clear, load, step-up and step-down rules (R1–R3);
- the hold rule (R4);
- the fact that a low carry only ever appears with `en_t_n` low and the count at 0 or 15 (R5).

The following are shown only by the bench's scenarios:
- that the carry follows a direction toggle between clock edges (R5);
- that `en_p_n` leaves the carry unchanged (R6);
- that two chained stages count correctly through both 8-bit wraps (R7).

The bench shows these by comparing each cycle against an arithmetic 8-bit reference.

// File: rtl/updown_counter4.sv
module updown_counter4 #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_n,
  input  logic             en_p_n,
  input  logic             en_t_n,
  input  logic             up,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] q,
  output logic             carry_n
);
  localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  logic step;
  logic at_end;

  assign step   = ~en_p_n & ~en_t_n;
  assign at_end = up ? (q == TOP) : (q == '0);

  always_ff @(posedge clk) begin
    if (rst)          q <= '0;
    else if (!load_n) q <= din;
    else if (step)    q <= up ? q + ONE : q - ONE;
  end

  assign carry_n = ~(~en_t_n & at_end);
endmodule

// File: rtl/updown_counter4_checks.sv
module updown_counter4_checks #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             load_n,
  input logic             en_p_n,
  input logic             en_t_n,
  input logic             up,
  input logic [WIDTH-1:0] din,
  input logic [WIDTH-1:0] q,
  input logic             carry_n
);
  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  a_r1_clear: assert property (@(posedge clk) rst |=> q == '0);

  a_r2_load: assert property (@(posedge clk) disable iff (rst)
    !load_n |=> q == $past(din));

  a_r3_count_up: assert property (@(posedge clk) disable iff (rst)
    (load_n && !en_p_n && !en_t_n && up) |=> q == $past(q) + ONE);

  a_r3_count_down: assert property (@(posedge clk) disable iff (rst)
    (load_n && !en_p_n && !en_t_n && !up) |=> q == $past(q) - ONE);

  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    (load_n && (en_p_n || en_t_n)) |=> $stable(q));

  a_r5_carry_gated: assert property (@(posedge clk) disable iff (rst)
    !carry_n |-> !en_t_n);

  a_r5_carry_at_end: assert property (@(posedge clk) disable iff (rst)
    !carry_n |-> (q == '0 || q == {WIDTH{1'b1}}));
endmodule

bind updown_counter4 updown_counter4_checks #(.WIDTH(WIDTH)) u_checks (.*);

// File: tb/test_updown_counter4.sv
module test_updown_counter4;
  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       load_n = 1'b1;
  logic       en_p_n = 1'b1;
  logic       en_t_n = 1'b1;
  logic       up = 1'b1;
  logic [7:0] din = 8'h00;
  logic [3:0] q_lo, q_hi;
  logic       c_lo, c_hi;

  int checks = 0;
  int errors = 0;
  logic [7:0] ref_q = 8'h00;

  always #(PERIOD/2) clk = ~clk;

  updown_counter4 #(.WIDTH(4)) i_updown_counter4 (
    .clk(clk), .rst(rst), .load_n(load_n), .en_p_n(en_p_n), .en_t_n(en_t_n),
    .up(up), .din(din[3:0]), .q(q_lo), .carry_n(c_lo));

  updown_counter4 #(.WIDTH(4)) i_hi (
    .clk(clk), .rst(rst), .load_n(load_n), .en_p_n(en_p_n), .en_t_n(c_lo),
    .up(up), .din(din[7:4]), .q(q_hi), .carry_n(c_hi));

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", tag, got, exp);
    end
  endtask

  function automatic logic exp_c_lo();
    return !(!en_t_n && (up ? ref_q[3:0] == 4'hF : ref_q[3:0] == 4'h0));
  endfunction

  function automatic logic exp_c_hi();
    return !(!en_t_n && (up ? ref_q == 8'hFF : ref_q == 8'h00));
  endfunction

  task automatic cyc(input logic r, input logic ld, input logic p, input logic t,
                     input logic u, input logic [7:0] d);
    rst = r; load_n = ld; en_p_n = p; en_t_n = t; up = u; din = d;
    #1;
    chk("R5 carry lo", c_lo, exp_c_lo());
    chk("R7 carry hi", c_hi, exp_c_hi());
    @(posedge clk);
    if (r)            ref_q = 8'h00;
    else if (!ld)     ref_q = d;
    else if (!p && !t) ref_q = u ? ref_q + 8'd1 : ref_q - 8'd1;
    @(negedge clk);
    chk("R7 count", {q_hi, q_lo}, ref_q);
  endtask

  initial begin
    #(PERIOD * 50000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    cyc(1, 1, 1, 1, 1, 8'h00);
    chk("R1 reset", {q_hi, q_lo}, 0);
    cyc(0, 0, 1, 1, 1, 8'hA5);
    chk("R2 load", {q_hi, q_lo}, 8'hA5);
    cyc(1, 0, 0, 0, 1, 8'h3C);
    chk("R1 reset over load", {q_hi, q_lo}, 0);
    cyc(0, 0, 0, 0, 0, 8'h7E);
    chk("R2 load over count", {q_hi, q_lo}, 8'h7E);

    // R3 R7: full up sweep through 255->0
    cyc(0, 0, 1, 1, 1, 8'hF0);
    for (int i = 0; i < 300; i++) cyc(0, 1, 0, 0, 1, 8'h00);
    // R3 R7: full down sweep through 0->255
    cyc(0, 0, 1, 1, 0, 8'h10);
    for (int i = 0; i < 300; i++) cyc(0, 1, 0, 0, 0, 8'h00);

    // load during counting
    for (int i = 0; i < 5; i++) cyc(0, 1, 0, 0, 1, 8'h00);
    cyc(0, 0, 0, 0, 1, 8'h0F);
    chk("R2 load mid-count", {q_hi, q_lo}, 8'h0F);

    // R4 hold: P high T low, then T high
    for (int i = 0; i < 4; i++) cyc(0, 1, 1, 0, 1, 8'h00);
    chk("R4 hold p", {q_hi, q_lo}, 8'h0F);
    for (int i = 0; i < 4; i++) cyc(0, 1, 0, 1, 0, 8'h00);
    chk("R4 hold t", {q_hi, q_lo}, 8'h0F);

    // R5: direction toggles carry between edges at 15 and 0
    en_p_n = 1; en_t_n = 0; load_n = 1; up = 1; #1;
    chk("R5 up at 15", c_lo, 0);
    up = 0; #1;
    chk("R5 down at 15", c_lo, 1);
    en_t_n = 1; up = 1; #1;
    chk("R5 t gates carry", c_lo, 1);
    cyc(0, 0, 1, 1, 0, 8'h30);
    en_t_n = 0; up = 0; #1;
    chk("R5 down at 0", c_lo, 0);
    up = 1; #1;
    chk("R5 up at 0", c_lo, 1);

    // R6: en_p_n does not change carry
    up = 0; en_p_n = 0; #1;
    chk("R6 p low", c_lo, 0);
    en_p_n = 1; #1;
    chk("R6 p high", c_lo, 0);

    // exhaustive load sweep
    for (int v = 0; v < 256; v++) begin
      cyc(0, 0, v[0], v[1], v[2], v[7:0]);
      chk("R2 load sweep", {q_hi, q_lo}, v);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule